// File: doc/BRIEF.md
# DMA Channel Cycle-Type Sequencer

This block steers one DMA channel through a complete cycle. It keeps two descriptors, called primary and alternate. Each descriptor holds a 3-bit cycle type, a count of transfers still to do, and a 4-bit burst exponent R. One bit selects which descriptor is active. When the channel is enabled and a request arrives, the block asks the channel arbiter for the bus. After a grant it issues a burst of transfer strobes, and each strobe is closed by an acknowledge. It then gives the bus back. Address generation and the bus protocol live outside the block and appear here only as these handshakes.

The cycle type decides what happens between bursts. In basic cycles the block waits for a fresh request. In autorequest cycles it asks for the bus again on its own. In ping-pong cycles it switches to the other descriptor when one finishes. A cycle started by a software request runs its bursts without further requests, and this carries across the ping-pong switch. When a descriptor's count runs out, the block pulses a done output and writes that descriptor back as empty and invalid.

Top module: `dma_cycle_seq`

## Requirements
- R1: Cycle type 3'b001 is basic, 3'b010 is autorequest and 3'b011 is ping-pong. A descriptor is unusable if it has any other type or a zero count. If a request finds the active descriptor unusable, no transfer is made and `ch_en_o` goes low.
- R2: After a grant, `xfer_o` stays high until min(2^R, N) acknowledges have been taken. N is the remaining count of the active descriptor.
- R3: In a basic cycle, a burst that leaves transfers remaining returns the channel to idle. `arb_req_o` stays low until a new request arrives.
- R4: In an autorequest cycle, one request drives the whole cycle. After each burst, `arb_req_o` rises again without any request. No new burst starts while the grant is withheld.
- R5: `xfer_o` rises only in the cycle after a cycle in which `arb_req_o` and `arb_gnt_i` were both high.
- R6: `done_o` is a one-cycle pulse. It appears in the cycle after the acknowledge that brings the remaining count to zero.
- R7: When a descriptor completes, it reads back with count 0 and type 3'b000.
- R8: When a ping-pong descriptor completes, `act_alt_o` flips. The next half then runs like a basic cycle and needs its own request.
- R9: At a ping-pong switch, if the other descriptor is unusable, `ch_en_o` goes low and no further transfer is made.
- R10: A software request (`sw_req_i`) on a ping-pong descriptor makes every following burst request the bus by itself, across switches. The run ends when an autorequest descriptor completes, and `ch_en_o` then goes low.
- R11: Requests that arrive while the channel is already busy are held as one pending flag. Several such requests produce at most one further burst.
- R12: `en_clr_i` stops the channel. Once the channel is disabled, `arb_req_o` falls and no burst starts.
- R13: When a basic or autorequest descriptor completes, `ch_en_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set_i | input | 1 | Enable-channel pulse |
| en_clr_i | input | 1 | Disable-channel pulse (wins over set) |
| req_i | input | 1 | Peripheral request pulse |
| sw_req_i | input | 1 | Software request pulse |
| arb_req_o | output | 1 | Bus request to channel arbiter |
| arb_gnt_i | input | 1 | Grant from channel arbiter |
| xfer_o | output | 1 | Transfer strobe, one transfer per acknowledge |
| xfer_ack_i | input | 1 | Transfer completion |
| ld_i | input | 1 | Descriptor write strobe |
| ld_alt_i | input | 1 | Descriptor write select, 1 = alternate |
| ld_type_i | input | 3 | Cycle type to write |
| ld_cnt_i | input | CNT_W | Transfer count to write |
| ld_pow_i | input | 4 | Burst exponent R to write |
| rd_alt_i | input | 1 | Descriptor readback select |
| rd_type_o | output | 3 | Read-back cycle type |
| rd_cnt_o | output | CNT_W | Read-back remaining count |
| done_o | output | 1 | Completion pulse |
| ch_en_o | output | 1 | Channel enable state |
| act_alt_o | output | 1 | Active descriptor, 1 = alternate |

## Verification
The assertions check four handshake rules on every cycle. Bursts start only after a grant to an enabled channel. The done pulse is one cycle wide and follows an acknowledge. A disabled, idle channel never raises its bus request. The bench scenarios cover the rest, which depends on sequences of events: burst lengths against min(2^R, N), basic cycles waiting for a request, autorequest cycles running from a single trigger, ping-pong flipping and stopping, the software-started run ending on its autorequest descriptor, the written-back descriptors, and requests collapsing into one pending flag.

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             req_i,
  input  logic             sw_req_i,
  output logic             arb_req_o,
  input  logic             arb_gnt_i,
  output logic             xfer_o,
  input  logic             xfer_ack_i,
  input  logic             ld_i,
  input  logic             ld_alt_i,
  input  logic [2:0]       ld_type_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic [3:0]       ld_pow_i,
  input  logic             rd_alt_i,
  output logic [2:0]       rd_type_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             done_o,
  output logic             ch_en_o,
  output logic             act_alt_o
);
  localparam logic [2:0] T_BASIC = 3'b001;
  localparam logic [2:0] T_AUTO  = 3'b010;
  localparam logic [2:0] T_PING  = 3'b011;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_XFER} st_t;
  st_t st;

  logic [2:0]       dtype [2];
  logic [CNT_W-1:0] dcnt  [2];
  logic [3:0]       dpow  [2];
  logic             en, act, pend, psw, swm, done;
  logic [CNT_W-1:0] bleft;

  function automatic logic usable(input logic [2:0] t, input logic [CNT_W-1:0] c);
    return (t == T_BASIC || t == T_AUTO || t == T_PING) && c != '0;
  endfunction

  logic [2:0]       cur_t;
  logic [CNT_W-1:0] cur_c;
  logic [CNT_W:0]   lim;
  logic [CNT_W-1:0] blen;
  logic             nxt_ok;

  assign cur_t  = dtype[act];
  assign cur_c  = dcnt[act];
  assign nxt_ok = usable(dtype[~act], dcnt[~act]);
  assign lim    = ({28'd0, dpow[act]} >= 32'(CNT_W)) ? {1'b1, {CNT_W{1'b0}}}
                                                     : (CNT_W+1)'(1) << dpow[act];
  assign blen   = ({1'b0, cur_c} < lim) ? cur_c : lim[CNT_W-1:0];

  assign arb_req_o = (st == S_ARB);
  assign xfer_o    = (st == S_XFER);
  assign done_o    = done;
  assign ch_en_o   = en;
  assign act_alt_o = act;
  assign rd_type_o = dtype[rd_alt_i];
  assign rd_cnt_o  = dcnt[rd_alt_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      en    <= 1'b0;
      act   <= 1'b0;
      pend  <= 1'b0;
      psw   <= 1'b0;
      swm   <= 1'b0;
      done  <= 1'b0;
      bleft <= '0;
      for (int i = 0; i < 2; i++) begin
        dtype[i] <= '0;
        dcnt[i]  <= '0;
        dpow[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      pend <= pend | req_i | sw_req_i;
      psw  <= psw | sw_req_i;
      if (en_set_i) en <= 1'b1;

      case (st)
        S_IDLE: if (en && pend) begin
          pend <= req_i | sw_req_i;
          psw  <= sw_req_i;
          if (usable(cur_t, cur_c)) begin
            st  <= S_ARB;
            swm <= psw;
          end else begin
            en <= 1'b0;
          end
        end
        S_ARB: begin
          if (!en) st <= S_IDLE;
          else if (arb_gnt_i) begin
            st    <= S_XFER;
            bleft <= blen;
          end
        end
        S_XFER: if (xfer_ack_i) begin
          dcnt[act] <= cur_c - CNT_W'(1);
          bleft     <= bleft - CNT_W'(1);
          if (cur_c == CNT_W'(1)) begin
            done       <= 1'b1;
            dtype[act] <= 3'b000;
            if (cur_t == T_PING) begin
              act <= ~act;
              if (!nxt_ok) begin
                en <= 1'b0; st <= S_IDLE; swm <= 1'b0; pend <= 1'b0; psw <= 1'b0;
              end else if (en && swm) st <= S_ARB;
              else st <= S_IDLE;
            end else begin
              en <= 1'b0; st <= S_IDLE; swm <= 1'b0; pend <= 1'b0; psw <= 1'b0;
            end
          end else if (bleft == CNT_W'(1)) begin
            if (en && (cur_t == T_AUTO || swm)) st <= S_ARB;
            else st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (en_clr_i) en <= 1'b0;
      if (ld_i) begin
        dtype[ld_alt_i] <= ld_type_i;
        dcnt[ld_alt_i]  <= ld_cnt_i;
        dpow[ld_alt_i]  <= ld_pow_i;
      end
    end
  end
endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_req_o,
  input logic arb_gnt_i,
  input logic xfer_o,
  input logic xfer_ack_i,
  input logic done_o,
  input logic ch_en_o
);
  a_r5_xfer_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_o) |-> $past(arb_req_o && arb_gnt_i));

  a_r12_xfer_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_o) |-> $past(ch_en_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(xfer_o && xfer_ack_i));

  a_r12_idle_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en_o && !arb_req_o) |=> !arb_req_o);
endmodule

bind dma_cycle_seq dma_cycle_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .arb_req_o(arb_req_o), .arb_gnt_i(arb_gnt_i),
  .xfer_o(xfer_o), .xfer_ack_i(xfer_ack_i), .done_o(done_o), .ch_en_o(ch_en_o)
);

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb_top;
  localparam int CW = 10;
  logic clk = 0, rst_n = 0;
  logic en_set = 0, en_clr = 0, req = 0, sw = 0, gnt = 0, ack = 0;
  logic ld = 0, ld_alt = 0, rd_alt = 0;
  logic [2:0] ld_type = 0;
  logic [CW-1:0] ld_cnt = 0;
  logic [3:0] ld_pow = 0;
  logic arb_req, xfer, done, ch_en, act_alt;
  logic [2:0] rd_type;
  logic [CW-1:0] rd_cnt;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_cycle_seq #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_set_i(en_set), .en_clr_i(en_clr),
    .req_i(req), .sw_req_i(sw), .arb_req_o(arb_req), .arb_gnt_i(gnt),
    .xfer_o(xfer), .xfer_ack_i(ack), .ld_i(ld), .ld_alt_i(ld_alt),
    .ld_type_i(ld_type), .ld_cnt_i(ld_cnt), .ld_pow_i(ld_pow),
    .rd_alt_i(rd_alt), .rd_type_o(rd_type), .rd_cnt_o(rd_cnt),
    .done_o(done), .ch_en_o(ch_en), .act_alt_o(act_alt));

  // {R, N, expected first burst}
  localparam int TBL [7][3] = '{'{0,5,1}, '{2,10,4}, '{3,5,5}, '{4,16,16},
                                '{1,2,2}, '{15,7,7}, '{3,8,8}};

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic load(input bit alt, input logic [2:0] t, input int n, input int p);
    ld = 1; ld_alt = alt; ld_type = t; ld_cnt = CW'(n); ld_pow = 4'(p);
    tick(); ld = 0;
  endtask

  task automatic pulse_en(); en_set = 1; tick(); en_set = 0; endtask
  task automatic pulse_req(); req = 1; tick(); req = 0; endtask

  task automatic grant_wait(output bit ok);
    ok = 0;
    for (int i = 0; i < 8; i++) begin
      if (arb_req) begin ok = 1; break; end
      tick();
    end
    if (ok) begin gnt = 1; tick(); gnt = 0; end
  endtask

  task automatic burst(output int n, output bit d);
    n = 0; d = 0;
    if (!xfer) return;
    ack = 1;
    for (int i = 0; i < 5000; i++) begin
      tick(); n++;
      if (done) d = 1;
      if (!xfer) break;
    end
    ack = 0;
  endtask

  task automatic serve(output int nb, output int tot, output int first, output int dn);
    bit ok, d; int n;
    nb = 0; tot = 0; first = 0; dn = 0;
    for (int i = 0; i < 64; i++) begin
      grant_wait(ok);
      if (!ok) break;
      burst(n, d);
      if (nb == 0) first = n;
      nb++; tot += n; dn += int'(d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int nb, tot, first, dn, n; bit d, ok;
    repeat (3) tick();
    rst_n = 1; tick();
    chk(!ch_en && !arb_req && !xfer && !done, "reset", int'({ch_en, arb_req, xfer, done}), 0);
    chk(rd_type == 0 && rd_cnt == 0, "reset descriptor", int'(rd_type), 0);

    // R2: burst length table
    foreach (TBL[k]) begin
      load(0, 3'b001, TBL[k][1], TBL[k][0]);
      pulse_en(); pulse_req();
      grant_wait(ok); burst(n, d);
      chk(n == TBL[k][2], "R2 burst length", n, TBL[k][2]);
      en_clr = 1; tick(); en_clr = 0; tick();
    end

    // R3 R6 R7 R13: basic cycle, N=5, R=1
    load(0, 3'b001, 5, 1); pulse_en(); pulse_req();
    serve(nb, tot, first, dn);
    chk(nb == 1 && tot == 2, "R3 one burst per request", tot, 2);
    chk(!arb_req && rd_cnt == 3, "R3 waits for request", int'(rd_cnt), 3);
    pulse_req(); serve(nb, tot, first, dn);
    pulse_req(); serve(nb, tot, first, dn);
    chk(tot == 1 && dn == 1, "R6 done on last transfer", dn, 1);
    tick();
    chk(!done, "R6 done one cycle", int'(done), 0);
    chk(rd_type == 0 && rd_cnt == 0, "R7 writeback", int'(rd_type), 0);
    chk(!ch_en, "R13 basic completion disables", int'(ch_en), 0);

    // R4: autorequest N=10 R=2, grant withheld once
    load(0, 3'b010, 10, 2); pulse_en(); pulse_req();
    grant_wait(ok); burst(n, d);
    chk(n == 4, "R4 first burst", n, 4);
    tick(); tick();
    ok = 1;
    for (int i = 0; i < 5; i++) begin
      if (xfer || !arb_req) ok = 0;
      tick();
    end
    chk(ok, "R4 waits for grant with request up", int'(ok), 1);
    serve(nb, tot, first, dn);
    chk(nb == 2 && tot == 6 && dn == 1, "R4 auto completion", tot, 6);
    chk(!ch_en, "R13 auto completion disables", int'(ch_en), 0);

    // R11: two requests while waiting collapse to one burst
    load(0, 3'b001, 12, 2); pulse_en(); pulse_req();
    for (int i = 0; i < 8 && !arb_req; i++) tick();
    pulse_req(); pulse_req();
    grant_wait(ok); burst(n, d);
    serve(nb, tot, first, dn);
    chk(nb == 1 && tot == 4, "R11 single pending", nb, 1);
    chk(rd_cnt == 4 && !arb_req, "R11 remaining", int'(rd_cnt), 4);
    en_clr = 1; tick(); en_clr = 0;

    // R12: disable while waiting for grant
    load(0, 3'b001, 4, 3); pulse_en(); pulse_req();
    for (int i = 0; i < 8 && !arb_req; i++) tick();
    en_clr = 1; tick(); en_clr = 0; tick(); tick();
    chk(!arb_req && !xfer, "R12 request dropped", int'(arb_req), 0);
    chk(rd_cnt == 4, "R12 no transfer", int'(rd_cnt), 4);

    // R1: invalid type 3'b101
    load(0, 3'b101, 4, 1); pulse_en(); pulse_req(); tick(); tick();
    chk(!ch_en && !arb_req, "R1 invalid clears enable", int'(ch_en), 0);
    chk(rd_cnt == 4, "R1 no transfer", int'(rd_cnt), 4);

    // R8 R9: ping-pong, primary N=3, alternate N=2
    load(0, 3'b011, 3, 3); load(1, 3'b011, 2, 3);
    pulse_en(); pulse_req();
    serve(nb, tot, first, dn);
    chk(tot == 3 && dn == 1, "R8 first half", tot, 3);
    chk(act_alt && ch_en && !arb_req, "R8 switched and waiting", int'(act_alt), 1);
    rd_alt = 0; tick();
    chk(rd_type == 0, "R7 primary written back", int'(rd_type), 0);
    pulse_req(); serve(nb, tot, first, dn);
    chk(tot == 2 && dn == 1, "R8 second half", tot, 2);
    chk(!ch_en && !act_alt, "R9 stop on invalid", int'(ch_en), 0);

    // R10: software ping-pong, final autorequest
    load(0, 3'b011, 3, 1); load(1, 3'b010, 3, 1);
    pulse_en(); sw = 1; tick(); sw = 0;
    serve(nb, tot, first, dn);
    chk(nb == 4 && tot == 6, "R10 self-requested bursts", nb, 4);
    chk(dn == 2 && !ch_en && act_alt, "R10 ends on autorequest", dn, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule